// File: doc/BRIEF.md
# Port-Layer Connection Manager State Machine

This block tracks, for each phy of a serial storage port, whether a connection is idle, waiting for the result of an open request, or established. It takes a connection request and single-cycle confirmations from the link layer and turns them into single-cycle messages for a separate open/close controller: retry the open, report that no connection could be made, or report that the connection has closed to idle.

A hard-reset confirmation is handled in every state, Idle included. During a link reset the phy-disabled and connection-closed confirmations normally come in first and have already returned the machine to Idle. The hard reset must still abort all operations and be forwarded to the transport layer, so it can never stall here. One independent machine is built per phy through a width parameter. An asynchronous active-low reset is applied at once and released through a two-stage synchronizer.

Top module: `cmgr_top`

## Requirements
- R1: While `rst_n` is low, every phy reports state code 0 (Idle) and all pulse outputs are 0. The state code is 0 for Idle, 1 for Request-Wait and 2 for Connected. Release takes effect on the second rising clock edge after `rst_n` goes high.
- R2: In Idle, a `conn_req` moves the phy to Request-Wait (code 1) at the next edge. In Request-Wait or Connected, `conn_req` has no effect.
- R3: In Request-Wait, `open_acc` moves the phy to Connected (code 2) with no message.
- R4: In Request-Wait, `open_rej` returns the phy to Idle. It pulses `msg_retry` when `rej_retry` is 1 and `msg_unable` when `rej_retry` is 0.
- R5: In Request-Wait, `phy_dis` returns the phy to Idle with no message. Among the Request-Wait events, `phy_dis` has the highest priority, then `open_rej`, then `open_acc`.
- R6: In Connected, `close_idle` returns the phy to Idle and pulses `msg_closed`. All other non-reset events are ignored in Connected.
- R7: A `hard_rst` in any state, Idle included, puts the phy in Idle at the next edge and pulses both `abort_ops` and `hr_up`. It overrides every other input of that cycle and sends no open/close message.
- R8: Every output pulse lasts one cycle per triggering event. At most one of `msg_retry`, `msg_unable`, `msg_closed` and `hr_up` is high per phy per cycle.
- R9: In Idle, every event other than `conn_req` and `hard_rst` leaves the state and all outputs unchanged.
- R10: Phys are independent: inputs to one phy never change the state or outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| conn_req | input | NUM_PHY | Connection request, one bit per phy |
| phy_dis | input | NUM_PHY | Phy-disabled confirmation |
| close_idle | input | NUM_PHY | Connection-closed-to-idle confirmation |
| hard_rst | input | NUM_PHY | Hard-reset-received confirmation |
| open_rej | input | NUM_PHY | Open request failed |
| rej_retry | input | NUM_PHY | Qualifies `open_rej`: 1 = retryable, 0 = give up |
| open_acc | input | NUM_PHY | Open request accepted |
| msg_retry | output | NUM_PHY | Retry-open message pulse |
| msg_unable | output | NUM_PHY | Unable-to-connect message pulse |
| msg_closed | output | NUM_PHY | Connection-closed-to-idle message pulse |
| abort_ops | output | NUM_PHY | Terminate-all-operations pulse |
| hr_up | output | NUM_PHY | Hard reset forwarded to transport |
| state_o | output | 2*NUM_PHY | Per-phy state code, phy p at bits [2p+1:2p] |

## Verification
The bench builds the block with NUM_PHY = 3, so the middle phy has neighbours on both sides and any leak between lanes shows up on either side. For every phy and each of the three start states, it applies all 128 combinations of the seven event inputs for one cycle. This covers every priority collision, including hard reset against phy-disabled. The bench compares next state and pulses with a model derived from the requirements, then checks that the pulses clear in the following cycle.

// File: rtl/cmgr_pkg.sv
package cmgr_pkg;

  localparam int ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    CM_IDLE = 2'd0,
    CM_WAIT = 2'd1,
    CM_CONN = 2'd2
  } cm_state_e;

  typedef struct packed {
    logic conn_req;
    logic phy_dis;
    logic close_idle;
    logic hard_rst;
    logic open_rej;
    logic rej_retry;
    logic open_acc;
  } cm_evt_t;

  typedef struct packed {
    logic retry;
    logic unable;
    logic closed;
    logic abort;
    logic hr_up;
  } cm_out_t;

endpackage

// File: rtl/cmgr_rst_sync.sv
module cmgr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  // asserted at once, released after STAGES rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/cmgr_phy_fsm.sv
module cmgr_phy_fsm
  import cmgr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cm_evt_t   evt,
  output cm_state_e state_o,
  output cm_out_t   out_o
);

  cm_state_e st_q, st_d;
  cm_out_t   out_q, out_d;

  // next state and next pulses; hard reset outranks every other event
  always_comb begin
    st_d  = st_q;
    out_d = '0;
    if (evt.hard_rst) begin
      st_d        = CM_IDLE;
      out_d.abort = 1'b1;
      out_d.hr_up = 1'b1;
    end else begin
      case (st_q)
        CM_IDLE: begin
          if (evt.conn_req) st_d = CM_WAIT;
        end
        CM_WAIT: begin
          if (evt.phy_dis) begin
            st_d = CM_IDLE;
          end else if (evt.open_rej) begin
            st_d = CM_IDLE;
            if (evt.rej_retry) out_d.retry  = 1'b1;
            else               out_d.unable = 1'b1;
          end else if (evt.open_acc) begin
            st_d = CM_CONN;
          end
        end
        CM_CONN: begin
          if (evt.close_idle) begin
            st_d         = CM_IDLE;
            out_d.closed = 1'b1;
          end
        end
        default: st_d = CM_IDLE;
      endcase
    end
  end

  // registers: state and pulses update every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CM_IDLE;
      out_q <= '0;
    end else begin
      st_q  <= st_d;
      out_q <= out_d;
    end
  end

  assign state_o = st_q;
  assign out_o   = out_q;

  // R7: hard reset from any state ends in Idle with abort and forward
  a_r7_hard_reset: assert property (@(posedge clk) disable iff (!rst_n)
    evt.hard_rst |=> (st_q == CM_IDLE && out_q.abort && out_q.hr_up &&
                      !out_q.retry && !out_q.unable && !out_q.closed));

  // R2: request accepted in Idle
  a_r2_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CM_IDLE && evt.conn_req && !evt.hard_rst) |=> st_q == CM_WAIT);

  // R5: phy disabled in Request-Wait returns silently
  a_r5_phy_dis: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CM_WAIT && evt.phy_dis && !evt.hard_rst) |=>
      (st_q == CM_IDLE && out_q == '0));

  // R4: retry / unable only leave Request-Wait
  a_r4_fail_src: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q.retry || out_q.unable) |-> $past(st_q) == CM_WAIT);

  // R6: closed message only leaves Connected
  a_r6_closed_src: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.closed |-> $past(st_q) == CM_CONN);

  // R8: one outbound message per cycle
  a_r8_one_msg: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_q.retry, out_q.unable, out_q.closed, out_q.hr_up}));

endmodule

// File: rtl/cmgr_top.sv
module cmgr_top
  import cmgr_pkg::*;
#(
  parameter int NUM_PHY = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_PHY-1:0]      conn_req,
  input  logic [NUM_PHY-1:0]      phy_dis,
  input  logic [NUM_PHY-1:0]      close_idle,
  input  logic [NUM_PHY-1:0]      hard_rst,
  input  logic [NUM_PHY-1:0]      open_rej,
  input  logic [NUM_PHY-1:0]      rej_retry,
  input  logic [NUM_PHY-1:0]      open_acc,
  output logic [NUM_PHY-1:0]      msg_retry,
  output logic [NUM_PHY-1:0]      msg_unable,
  output logic [NUM_PHY-1:0]      msg_closed,
  output logic [NUM_PHY-1:0]      abort_ops,
  output logic [NUM_PHY-1:0]      hr_up,
  output logic [NUM_PHY*ST_W-1:0] state_o
);

  logic rst_n_sync;

  cmgr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  for (genvar g = 0; g < NUM_PHY; g++) begin : g_phy
    cm_evt_t   evt;
    cm_out_t   pout;
    cm_state_e st;

    assign evt = '{conn_req:   conn_req[g],
                   phy_dis:    phy_dis[g],
                   close_idle: close_idle[g],
                   hard_rst:   hard_rst[g],
                   open_rej:   open_rej[g],
                   rej_retry:  rej_retry[g],
                   open_acc:   open_acc[g]};

    cmgr_phy_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n_sync),
      .evt     (evt),
      .state_o (st),
      .out_o   (pout)
    );

    assign msg_retry[g]              = pout.retry;
    assign msg_unable[g]             = pout.unable;
    assign msg_closed[g]             = pout.closed;
    assign abort_ops[g]              = pout.abort;
    assign hr_up[g]                  = pout.hr_up;
    assign state_o[g*ST_W +: ST_W]   = st;
  end

endmodule

// File: tb/cmgr_top_test.sv
`timescale 1ns/1ps
module cmgr_top_test;

  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] conn_req = '0, phy_dis = '0, close_idle = '0, hard_rst = '0;
  logic [N-1:0] open_rej = '0, rej_retry = '0, open_acc = '0;
  logic [N-1:0] msg_retry, msg_unable, msg_closed, abort_ops, hr_up;
  logic [2*N-1:0] state_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cmgr_top #(.NUM_PHY(N)) uut (
    .clk(clk), .rst_n(rst_n),
    .conn_req(conn_req), .phy_dis(phy_dis), .close_idle(close_idle),
    .hard_rst(hard_rst), .open_rej(open_rej), .rej_retry(rej_retry),
    .open_acc(open_acc),
    .msg_retry(msg_retry), .msg_unable(msg_unable), .msg_closed(msg_closed),
    .abort_ops(abort_ops), .hr_up(hr_up), .state_o(state_o)
  );

  // event bit order: 0 conn_req,1 phy_dis,2 close_idle,3 hard_rst,
  // 4 open_rej,5 rej_retry,6 open_acc
  // result: {state[1:0], retry, unable, closed, abort, hr_up}
  function automatic logic [6:0] model(input logic [1:0] st, input logic [6:0] ev);
    if (ev[3])                       return {2'd0, 5'b00011};        // R7
    if (st == 2'd0) return ev[0] ? {2'd1, 5'b0} : {2'd0, 5'b0};      // R2 / R9
    if (st == 2'd1) begin
      if (ev[1]) return {2'd0, 5'b0};                                // R5
      if (ev[4]) return ev[5] ? {2'd0, 5'b10000} : {2'd0, 5'b01000}; // R4
      if (ev[6]) return {2'd2, 5'b0};                                // R3
      return {2'd1, 5'b0};
    end
    return ev[2] ? {2'd0, 5'b00100} : {2'd2, 5'b0};                  // R6
  endfunction

  function automatic string tag(input logic [1:0] st, input logic [6:0] ev);
    if (ev[3])      return "R7";
    if (st == 2'd0) return ev[0] ? "R2" : "R9";
    if (st == 2'd1) return ev[1] ? "R5" : (ev[4] ? "R4" : (ev[6] ? "R3" : "R2"));
    return "R6";
  endfunction

  function automatic logic [6:0] actual(input int p);
    return {state_o[2*p +: 2], msg_retry[p], msg_unable[p], msg_closed[p],
            abort_ops[p], hr_up[p]};
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    conn_req = '0; phy_dis = '0; close_idle = '0; hard_rst = '0;
    open_rej = '0; rej_retry = '0; open_acc = '0;
  endtask

  task automatic drive(input int p, input logic [6:0] ev);
    clear_inputs();
    conn_req[p] = ev[0]; phy_dis[p] = ev[1]; close_idle[p] = ev[2];
    hard_rst[p] = ev[3]; open_rej[p] = ev[4]; rej_retry[p] = ev[5];
    open_acc[p] = ev[6];
  endtask

  // inputs set at negedge, registered at posedge, sampled next negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_state(input int p, input logic [1:0] st);
    drive(p, 7'b0001000); step();
    if (st >= 2'd1) begin drive(p, 7'b0000001); step(); end
    if (st == 2'd2) begin drive(p, 7'b1000000); step(); end
    clear_inputs(); step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset holds Idle and silence even with a request present
    @(negedge clk);
    conn_req = '1;
    repeat (3) step();
    for (int p = 0; p < N; p++) check("R1 in reset", actual(p), 7'b0);
    clear_inputs();
    rst_n = 1'b1;
    repeat (4) step();
    for (int p = 0; p < N; p++) check("R1 after release", actual(p), 7'b0);

    for (int p = 0; p < N; p++) begin
      for (int s = 0; s < 3; s++) begin
        for (int c = 0; c < 128; c++) begin
          logic [6:0] exp;
          go_state(p, s[1:0]);
          check("R2/R3 setup", actual(p), {s[1:0], 5'b0});
          drive(p, c[6:0]);
          step();
          exp = model(s[1:0], c[6:0]);
          check(tag(s[1:0], c[6:0]), actual(p), exp);
          for (int q = 0; q < N; q++)
            if (q != p) check("R10 neighbour", actual(q), 7'b0);
          clear_inputs();
          step();
          check("R8 pulse cleared", actual(p), {exp[6:5], 5'b0});
        end
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule